// File: doc/BRIEF.md
# Receive Error Tally Counter Bank

This block keeps three small event tallies for a 10 Mb/s Ethernet receive path: frames that failed the CRC check, frames that ended off a byte boundary (alignment errors), and frames dropped because no buffer space was left (missed packets). The receive logic that detects these events sends the block a one-cycle strobe for each event, and each strobe adds one to the matching tally. A tally never rolls over. Once it reaches its ceiling of 192, further strobes leave it there.

Host software reads a tally through a simple strobe-plus-address port. A read returns the current value on a registered data output in the cycle after the read, and it clears that tally to zero. The host therefore sees the number of events since its last read. To keep the host from polling, the block raises an event flag as soon as any tally reaches 128. The flag stays up until every tally that crossed 128 has been read.

Top module: `err_tally`

## Requirements
- R1: A synchronous active-high reset sets all three tallies, the read data output and the event flag to zero.
- R2: Each strobe (inc_crc, inc_align, inc_miss) adds exactly one to its own tally on the clock edge where it is high, and leaves the other tallies alone.
- R3: A tally saturates at 192 (0xC0). A strobe that arrives while the tally is at 192 leaves it at 192, and rd_data never shows a value above 192.
- R4: Address encoding: 0 selects the CRC tally, 1 the alignment tally and 2 the missed-packet tally. When rd_en is high at a clock edge, rd_data shows the selected tally's value from before that edge, starting just after that edge, and the tally becomes zero.
- R5: If a read and a strobe hit the same tally in the same cycle, the read returns the old value and the tally ends at 1. This holds even when the old value is 192.
- R6: A read with address 3 returns 0 and changes no tally.
- R7: event_flag rises on the edge where any tally reaches 128. It stays high until each tally that reached 128 has been read. A read of one such tally does not drop the flag while another tally is still flagged.
- R8: rd_data holds its value in every cycle in which rd_en is low.
- R9: Strobes to different tallies in the same cycle are all counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inc_crc | input | 1 | One-cycle strobe: CRC error seen |
| inc_align | input | 1 | One-cycle strobe: alignment error seen |
| inc_miss | input | 1 | One-cycle strobe: missed packet |
| rd_en | input | 1 | Host read strobe; clears the addressed tally |
| rd_addr | input | 2 | Tally select (0 CRC, 1 alignment, 2 missed, 3 unused) |
| rd_data | output | 8 | Registered read data, held between reads |
| event_flag | output | 1 | High while any tally that reached 128 is still unread |

## Verification
The bench drives a tally far past 192 and reads it. A counter that wrapped would return a small number, and one with no ceiling would return more than 192. It reads a tally on the same cycle that a strobe arrives, both in mid-range and at saturation. A design that gave the read priority would leave the tally at 0, and one that missed the collision would return the new value. The bench also pushes two tallies past 128 and reads them one at a time. A flag kept as a single bit would drop on the first read, and a missing clear would keep the flag up after both reads. Finally, a read of the unused address must neither return nor clear any tally.

// File: rtl/err_tally_pkg.sv
package err_tally_pkg;
  localparam int TALLY_W    = 8;
  localparam int TALLY_NUM  = 3;
  localparam int TALLY_SAT  = 192;
  localparam int TALLY_FLAG = 128;

  typedef enum logic [1:0] {
    SEL_CRC   = 2'd0,
    SEL_ALIGN = 2'd1,
    SEL_MISS  = 2'd2,
    SEL_NONE  = 2'd3
  } tally_sel_e;
endpackage

// File: rtl/err_tally_counter.sv
module err_tally_counter #(
  parameter int W      = 8,
  parameter int SAT    = 192,
  parameter int FLAG_AT = 128
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  input  logic         clr,
  output logic [W-1:0] cnt,
  output logic         hit
);
  localparam logic [W-1:0] SAT_V  = W'(SAT);
  localparam logic [W-1:0] FLAG_V = W'(FLAG_AT);

  logic [W-1:0] cnt_d;

  always_comb begin
    if (clr)
      cnt_d = inc ? W'(1) : '0;
    else if (inc && cnt != SAT_V)
      cnt_d = cnt + W'(1);
    else
      cnt_d = cnt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      hit <= 1'b0;
    end else begin
      cnt <= cnt_d;
      if (clr)
        hit <= 1'b0;
      else if (cnt_d >= FLAG_V)
        hit <= 1'b1;
    end
  end
endmodule

// File: rtl/err_tally_rdport.sv
module err_tally_rdport #(
  parameter int W   = 8,
  parameter int NUM = 3,
  parameter int AW  = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rd_en,
  input  logic [AW-1:0]        rd_addr,
  input  logic [NUM-1:0][W-1:0] cnt,
  output logic [NUM-1:0]       clr,
  output logic [W-1:0]         rd_data
);
  logic [W-1:0] sel;

  always_comb begin
    sel = '0;
    for (int i = 0; i < NUM; i++)
      if (rd_addr == AW'(i)) sel = cnt[i];
  end

  generate
    for (genvar g = 0; g < NUM; g++) begin : g_clr
      assign clr[g] = rd_en && (rd_addr == AW'(g));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)
      rd_data <= '0;
    else if (rd_en)
      rd_data <= sel;
  end
endmodule

// File: rtl/err_tally.sv
module err_tally
  import err_tally_pkg::*;
#(
  parameter int W       = TALLY_W,
  parameter int SAT     = TALLY_SAT,
  parameter int FLAG_AT = TALLY_FLAG,
  parameter int AW      = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inc_crc,
  input  logic          inc_align,
  input  logic          inc_miss,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data,
  output logic          event_flag
);
  localparam int NUM = TALLY_NUM;

  logic [NUM-1:0]        inc_v;
  logic [NUM-1:0]        clr_v;
  logic [NUM-1:0]        hit_v;
  logic [NUM-1:0][W-1:0] cnt_v;

  assign inc_v[SEL_CRC]   = inc_crc;
  assign inc_v[SEL_ALIGN] = inc_align;
  assign inc_v[SEL_MISS]  = inc_miss;

  generate
    for (genvar g = 0; g < NUM; g++) begin : g_tally
      err_tally_counter #(.W(W), .SAT(SAT), .FLAG_AT(FLAG_AT)) u_cnt (
        .clk (clk),
        .rst (rst),
        .inc (inc_v[g]),
        .clr (clr_v[g]),
        .cnt (cnt_v[g]),
        .hit (hit_v[g])
      );
    end
  endgenerate

  err_tally_rdport #(.W(W), .NUM(NUM), .AW(AW)) u_rd (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .cnt     (cnt_v),
    .clr     (clr_v),
    .rd_data (rd_data)
  );

  assign event_flag = |hit_v;
endmodule

// File: rtl/err_tally_checker.sv
module err_tally_checker #(
  parameter int W   = 8,
  parameter int SAT = 192,
  parameter int AW  = 2,
  parameter int NUM = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          inc_crc,
  input logic          inc_align,
  input logic          inc_miss,
  input logic          rd_en,
  input logic [AW-1:0] rd_addr,
  input logic [W-1:0]  rd_data,
  input logic          event_flag
);
  // R1
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (rd_data == '0 && !event_flag));

  // R3
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
    rd_data <= W'(SAT));

  // R6
  a_r6_unused_addr: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_addr >= AW'(NUM)) |=> rd_data == '0);

  // R8
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));

  // R7: flag drops only after a read
  a_r7_flag_fall: assert property (@(posedge clk) disable iff (rst)
    $fell(event_flag) |-> $past(rd_en));

  // R7: flag rises only after a strobe
  a_r7_flag_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(event_flag) |-> $past(inc_crc || inc_align || inc_miss));
endmodule

bind err_tally err_tally_checker #(.W(W), .SAT(SAT), .AW(AW), .NUM(NUM)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .inc_crc    (inc_crc),
  .inc_align  (inc_align),
  .inc_miss   (inc_miss),
  .rd_en      (rd_en),
  .rd_addr    (rd_addr),
  .rd_data    (rd_data),
  .event_flag (event_flag)
);

// File: tb/err_tally_test.sv
`timescale 1ns/1ps
module err_tally_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       inc_crc = 1'b0, inc_align = 1'b0, inc_miss = 1'b0;
  logic       rd_en = 1'b0;
  logic [1:0] rd_addr = 2'd0;
  logic [7:0] rd_data;
  logic       event_flag;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  err_tally uut (
    .clk(clk), .rst(rst),
    .inc_crc(inc_crc), .inc_align(inc_align), .inc_miss(inc_miss),
    .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .event_flag(event_flag)
  );

  // fields: inc{miss,align,crc}[17:15] rd[14] addr[13:12] req[11:8] exp rd_data[7:0]
  localparam logic [17:0] VEC [12] = '{
    {3'b001, 1'b0, 2'd0, 4'd8, 8'd0},   // R8 hold, crc=1
    {3'b011, 1'b0, 2'd0, 4'd9, 8'd0},   // R9 crc=2 align=1
    {3'b100, 1'b0, 2'd0, 4'd2, 8'd0},   // R2 miss=1
    {3'b000, 1'b1, 2'd0, 4'd4, 8'd2},   // R4 read crc
    {3'b010, 1'b1, 2'd1, 4'd5, 8'd1},   // R5 read align with strobe
    {3'b000, 1'b1, 2'd1, 4'd5, 8'd1},   // R5 align ended at 1
    {3'b001, 1'b1, 2'd2, 4'd4, 8'd1},   // R4 read miss, crc=1
    {3'b000, 1'b1, 2'd3, 4'd6, 8'd0},   // R6 unused address
    {3'b000, 1'b1, 2'd0, 4'd2, 8'd1},   // R2 crc counted once
    {3'b000, 1'b1, 2'd0, 4'd4, 8'd0},   // R4 cleared by read
    {3'b000, 1'b0, 2'd0, 4'd8, 8'd0},   // R8 idle hold
    {3'b000, 1'b1, 2'd2, 4'd4, 8'd0}    // R4 miss cleared
  };

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic [2:0] inc, input logic rd, input logic [1:0] addr);
    @(negedge clk);
    {inc_miss, inc_align, inc_crc} = inc;
    rd_en = rd;
    rd_addr = addr;
    @(posedge clk);
    #1;
    {inc_miss, inc_align, inc_crc} = 3'b000;
    rd_en = 1'b0;
  endtask

  task automatic bump(input logic [2:0] inc, input int n);
    for (int k = 0; k < n; k++) step(inc, 1'b0, 2'd0);
  endtask

  task automatic rd(input logic [1:0] addr, input string tag, input int exp);
    step(3'b000, 1'b1, addr);
    check(tag, rd_data, exp);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    rst = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    check("R1 rd_data after reset", rd_data, 0);
    check("R1 flag after reset", event_flag, 0);

    for (int i = 0; i < 12; i++) begin
      step(VEC[i][17:15], VEC[i][14], VEC[i][13:12]);
      total++;
      if (rd_data != VEC[i][7:0]) begin
        bad++;
        $display("FAIL R%0d table step %0d actual=%0d expected=%0d",
                 VEC[i][11:8], i, rd_data, VEC[i][7:0]);
      end
    end

    // R7 threshold edge
    do_reset();
    bump(3'b001, 127);
    check("R7 flag low at 127", event_flag, 0);
    bump(3'b001, 1);
    check("R7 flag high at 128", event_flag, 1);
    bump(3'b010, 130);
    bump(3'b001, 70);
    check("R7 flag still high", event_flag, 1);
    rd(2'd0, "R3 crc saturated at 192", 192);
    check("R7 flag kept by align tally", event_flag, 1);
    rd(2'd1, "R4 align value", 130);
    check("R7 flag cleared after both reads", event_flag, 0);

    // R5 collision at saturation
    bump(3'b001, 200);
    step(3'b001, 1'b1, 2'd0);
    check("R5 read at 192 with strobe", rd_data, 192);
    check("R7 flag cleared by collision read", event_flag, 0);
    rd(2'd0, "R5 tally ends at 1", 1);

    // R9 simultaneous strobes
    bump(3'b111, 5);
    rd(2'd0, "R9 crc", 5);
    rd(2'd1, "R9 align", 5);
    rd(2'd2, "R9 miss", 5);

    // R6 unused address leaves tallies alone
    bump(3'b001, 3);
    rd(2'd3, "R6 unused returns 0", 0);
    rd(2'd0, "R6 crc untouched", 3);

    // R1 reset mid-run
    bump(3'b100, 4);
    bump(3'b010, 129);
    do_reset();
    check("R1 flag after mid-run reset", event_flag, 0);
    check("R1 rd_data after mid-run reset", rd_data, 0);
    rd(2'd2, "R1 miss cleared by reset", 0);
    rd(2'd1, "R1 align cleared by reset", 0);

    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule